// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects interrupt events for a small 8-bit microcontroller core and turns them into vector requests. Each of the fourteen sources has a pending flag, an individual enable bit and a priority bit. A global enable bit masks all of them at once. Flags latch on every event, whether or not the source is enabled. Only enabled flags compete for service.

The core reports instruction completion with `insn_done` and return-from-interrupt with `reti`. The controller decides only on an `insn_done` cycle. When a source wins, it raises `irq_req` for one cycle, presents the vector address `0x0003 + 8*n`, and marks the winning level as in service. A high-priority source can interrupt a low-priority handler. No other preemption is allowed. Some sources clear their own flag when they are taken. The others keep the flag until software writes a 0, so a flag that is still set after a return is taken again at the next boundary.

The sequencer has two states. `ST_WAIT` waits for a boundary. `ST_VECT` is the one-cycle request state. The transition *take* goes from `ST_WAIT` to `ST_VECT` on an `insn_done` cycle that has an eligible source. The transition *finish* always goes from `ST_VECT` back to `ST_WAIT` on the next cycle.

Top module: `irq_vector_ctl`

## Requirements
- R1: After reset, `irq_req` is 0 and `svc_level` is 0. The enable, priority and flag registers all read 0.
- R2: An event pulse on `evt[n]` sets pending flag n whatever the enable state is. Flag n reads back at bit n of register address 2.
- R3: Source n is eligible only when enable bit n (address 0, bit n) and the global enable (address 0, bit 15) are both 1. With the global enable at 0, no request is made.
- R4: The controller decides only on a cycle with `insn_done`=1. `irq_req` is high for exactly the following cycle, and `irq_vec` = 0x0003 + 8*n. An event that arrives in the decision cycle itself waits for the next boundary.
- R5: Sources selected by `AUTO_CLR_MASK` (by default sources 0 and 2) clear their flag when taken. All other flags stay set.
- R6: A flag that is still set and enabled after `reti` is taken again at the next `insn_done`.
- R7: Writing to the flag register clears each flag whose data bit is 0. A data bit of 1 has no effect. An event in the same cycle as a clearing write leaves the flag set.
- R8: Priority bit n (address 1) set to 1 makes source n high priority. A high-priority source preempts a low-priority handler. A low-priority or same-level source never preempts an active handler.
- R9: An eligible high-priority source beats any low-priority one. Within one level, the lowest-numbered source wins.
- R10: In `svc_level`, bit 1 marks high priority in service and bit 0 marks low priority in service. The bit for the winner's level is set on a take, and `reti` clears the highest set bit.
- R11: The enable values held before a register write govern a decision made in the same cycle as that write. Reading the enable register afterwards returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 14 | Per-source event pulses |
| insn_done | input | 1 | Instruction-completion strobe from the core |
| reti | input | 1 | Return-from-interrupt strobe from the core |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enables, 1 priorities, 2 flags |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_req | output | 1 | One-cycle vector request to the core |
| irq_vec | output | 16 | Vector address of the winning source |
| svc_level | output | 2 | In-service bits: bit 1 high, bit 0 low |

## Verification
Each stimulus pattern isolates one cause of a request or its absence. The patterns are:
- a single disabled source, and one blocked by the global enable;
- two simultaneous sources at one level, and two split across levels;
- a high event raised during a low handler;
- a low flag left pending during a high handler;
- a flag left set across a return;
- an event that lands on a clearing write or on the decision cycle itself;
- an enable cleared in the decision cycle.

Each expected vector goes into a queue when the boundary is driven and is compared when the request appears. Any request that nothing predicted is a failure.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_VECT = 1'b1
    } irqc_state_e;

    typedef enum logic [1:0] {
        RA_ENABLE = 2'd0,
        RA_PRIO   = 2'd1,
        RA_FLAG   = 2'd2
    } irqc_reg_e;
endpackage

// File: rtl/irqc_flags.sv
module irqc_flags #(
    parameter int N = 14,
    parameter logic [N-1:0] AUTO_CLR = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         sw_wr,
    input  logic [N-1:0] sw_data,
    input  logic [N-1:0] taken,
    output logic [N-1:0] pend
);
    logic [N-1:0] clr;

    always_comb begin
        clr = (taken & AUTO_CLR);
        if (sw_wr) clr = clr | ~sw_data;
    end

    // event wins over any clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= evt | (pend & ~clr);
    end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int N = 14,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  elig_hi,
    input  logic [N-1:0]  elig_lo,
    output logic          found,
    output logic          win_hi,
    output logic [IW-1:0] win_idx
);
    logic [IW-1:0] idx_hi, idx_lo;

    always_comb begin
        idx_hi = '0;
        idx_lo = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig_hi[i]) idx_hi = IW'(i);
            if (elig_lo[i]) idx_lo = IW'(i);
        end
        win_hi  = |elig_hi;
        found   = |elig_hi | |elig_lo;
        win_idx = win_hi ? idx_hi : idx_lo;
    end
endmodule

// File: rtl/irqc_nest.sv
module irqc_nest (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       take_hi,
    input  logic       reti,
    output logic [1:0] svc
);
    logic [1:0] after_ret;

    always_comb begin
        after_ret = svc;
        if (reti) begin
            if (svc[1]) after_ret[1] = 1'b0;
            else        after_ret[0] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) svc <= 2'b00;
        else if (take) svc <= after_ret | (take_hi ? 2'b10 : 2'b01);
        else svc <= after_ret;
    end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 14,
    parameter int DW = 16,
    parameter int ADDR_W = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STRIDE = 8,
    parameter logic [NUM_SRC-1:0] AUTO_CLR_MASK = NUM_SRC'(5)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               insn_done,
    input  logic               reti,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    output logic               irq_req,
    output logic [ADDR_W-1:0]  irq_vec,
    output logic [1:0]         svc_level
);
    localparam int IW = $clog2(NUM_SRC);
    localparam int GIE_BIT = DW - 1;

    irqc_state_e state_q, state_d;
    logic [NUM_SRC-1:0] en_q, prio_q, pend_q;
    logic               gie_q;
    logic [NUM_SRC-1:0] base, elig_hi, elig_lo, taken;
    logic               found, win_hi, take;
    logic [IW-1:0]      win_idx;
    logic [ADDR_W-1:0]  vec_q;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            gie_q  <= 1'b0;
            prio_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == RA_ENABLE) begin
                en_q  <= reg_wdata[NUM_SRC-1:0];
                gie_q <= reg_wdata[GIE_BIT];
            end
            if (reg_addr == RA_PRIO) prio_q <= reg_wdata[NUM_SRC-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_ENABLE: begin
                reg_rdata[NUM_SRC-1:0] = en_q;
                reg_rdata[GIE_BIT]     = gie_q;
            end
            RA_PRIO: reg_rdata[NUM_SRC-1:0] = prio_q;
            RA_FLAG: reg_rdata[NUM_SRC-1:0] = pend_q;
            default: reg_rdata = '0;
        endcase
    end

    // eligibility with nesting rules
    always_comb begin
        base    = pend_q & en_q & {NUM_SRC{gie_q}};
        elig_hi = base & prio_q & {NUM_SRC{~svc_level[1]}};
        elig_lo = base & ~prio_q & {NUM_SRC{svc_level == 2'b00}};
    end

    irqc_arbiter #(.N(NUM_SRC)) u_arb (
        .elig_hi (elig_hi),
        .elig_lo (elig_lo),
        .found   (found),
        .win_hi  (win_hi),
        .win_idx (win_idx)
    );

    assign take  = (state_q == ST_WAIT) && insn_done && found;
    assign taken = take ? (NUM_SRC'(1) << win_idx) : '0;

    irqc_flags #(.N(NUM_SRC), .AUTO_CLR(AUTO_CLR_MASK)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .sw_wr   (reg_wr && (reg_addr == RA_FLAG)),
        .sw_data (reg_wdata[NUM_SRC-1:0]),
        .taken   (taken),
        .pend    (pend_q)
    );

    irqc_nest u_nest (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .take_hi (win_hi),
        .reti    (reti),
        .svc     (svc_level)
    );

    // sequencer: take (WAIT->VECT), finish (VECT->WAIT)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (take) state_d = ST_VECT;
            ST_VECT: state_d = ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take)
                vec_q <= ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(win_idx);
        end
    end

    always_comb begin
        irq_req = (state_q == ST_VECT);
        irq_vec = vec_q;
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int N = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic         insn_done,
    input logic         reti,
    input logic         irq_req,
    input logic [1:0]   svc_level,
    input logic         gie,
    input logic [N-1:0] evt,
    input logic [N-1:0] pend
);
    // R4
    req_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(insn_done));

    // R4
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

    // R3
    req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(gie));

    // R7
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((pend & $past(evt)) == $past(evt)));

    // R8
    low_only_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_level[0]) |-> ($past(svc_level) == 2'b00));

    // R10
    svc_set_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (svc_level != 2'b00));
endmodule

bind irq_vector_ctl irqc_chk #(.N(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_done (insn_done),
    .reti      (reti),
    .irq_req   (irq_req),
    .svc_level (svc_level),
    .gie       (gie_q),
    .evt       (evt),
    .pend      (pend_q)
);

// File: tb/irq_vector_ctl_test.sv
module irq_vector_ctl_test;
    localparam int N = 14;
    localparam logic [15:0] GIE = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] evt = '0;
    logic        insn_done = 1'b0, reti = 1'b0, reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0, reg_rdata, irq_vec;
    logic        irq_req;
    logic [1:0]  svc_level;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [15:0] expq[$];

    always #10 clk = ~clk;

    irq_vector_ctl uut (
        .clk(clk), .rst_n(rst_n), .evt(evt), .insn_done(insn_done), .reti(reti),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
        .svc_level(svc_level)
    );

    function automatic logic [15:0] vec_of(int n);
        return 16'(3 + 8 * n);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected vectors as requests appear
    always @(negedge clk) begin
        if (rst_n && irq_req) begin
            if (expq.size() == 0) chk(0, "R4 unexpected request", irq_vec, 0);
            else begin
                logic [15:0] e;
                e = expq.pop_front();
                chk(irq_vec == e, "R4/R9 vector", irq_vec, e);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk); evt = m;
        @(negedge clk); evt = '0;
    endtask

    // boundary; pushes expectation (or checks silence when exp_src < 0)
    task automatic boundary(input int exp_src, input string req);
        @(negedge clk);
        insn_done = 1;
        if (exp_src >= 0) expq.push_back(vec_of(exp_src));
        @(negedge clk); insn_done = 0;
        #1 if (exp_src < 0) chk(irq_req == 0, req, irq_req, 0);
    endtask

    task automatic do_reti;
        @(negedge clk); reti = 1;
        @(negedge clk); reti = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        #1 chk(irq_req == 0 && svc_level == 0, "R1 outputs", {irq_req, svc_level}, 0);
        rd(0, r); chk(r == 0, "R1 enable reg", r, 0);
        rd(1, r); chk(r == 0, "R1 prio reg", r, 0);
        rd(2, r); chk(r == 0, "R1 flag reg", r, 0);

        // R2 latch while disabled
        pulse(N'(1) << 5);
        rd(2, r); chk(r == 16'h0020, "R2 flag latched while disabled", r, 16'h0020);
        boundary(-1, "R3 disabled source silent");
        // R3 individual enable without global
        wr(0, 16'h0020);
        boundary(-1, "R3 global enable off");
        wr(0, GIE | 16'h0020);
        boundary(5, "");
        #1 chk(svc_level == 2'b01, "R10 low in service", svc_level, 1);
        // R5 non-auto source keeps flag
        rd(2, r); chk(r == 16'h0020, "R5 flag kept", r, 16'h0020);
        do_reti;
        #1 chk(svc_level == 0, "R10 reti clears", svc_level, 0);
        // R6 re-take after return
        boundary(5, "");
        do_reti;
        // R7 clear by writing 0
        wr(2, 16'hFFDF);
        rd(2, r); chk(r == 0, "R7 clear by 0", r, 0);
        boundary(-1, "R7 cleared flag silent");
        // R7 writing 1 no effect
        wr(2, 16'hFFFF);
        rd(2, r); chk(r == 0, "R7 write 1 no effect", r, 0);

        // R5 auto-clear source 2
        wr(0, GIE | 16'h0004);
        pulse(N'(1) << 2);
        boundary(2, "");
        rd(2, r); chk(r == 0, "R5 auto clear", r, 0);
        do_reti;

        // R8/R9 priority: src9 high, src3 low
        wr(1, 16'h0200);
        wr(0, GIE | 16'h0208);
        pulse((N'(1) << 9) | (N'(1) << 3));
        boundary(9, "");
        #1 chk(svc_level == 2'b10, "R10 high in service", svc_level, 2);
        boundary(-1, "R8 no preempt of high");
        do_reti;
        wr(2, 16'hFDFF);
        boundary(3, "");
        pulse(N'(1) << 9);
        boundary(9, "");
        #1 chk(svc_level == 2'b11, "R8 high preempts low", svc_level, 3);
        do_reti;
        #1 chk(svc_level == 2'b01, "R10 reti clears highest", svc_level, 1);
        do_reti;
        wr(2, 16'h0000);

        // R9 lowest index wins within level
        wr(1, 16'h0000);
        wr(0, GIE | 16'h0050);
        pulse((N'(1) << 6) | (N'(1) << 4));
        boundary(4, "");
        do_reti;
        wr(2, 16'h0000);

        // R7 event beats clearing write
        @(negedge clk); evt = N'(1) << 7; reg_wr = 1; reg_addr = 2; reg_wdata = 0;
        @(negedge clk); evt = '0; reg_wr = 0;
        rd(2, r); chk(r == 16'h0080, "R7 event wins over clear", r, 16'h0080);
        wr(2, 16'h0000);

        // R11 enable cleared in decision cycle
        wr(0, GIE | 16'h0002);
        pulse(N'(1) << 1);
        @(negedge clk);
        insn_done = 1; reg_wr = 1; reg_addr = 0; reg_wdata = GIE;
        expq.push_back(vec_of(1));
        @(negedge clk); insn_done = 0; reg_wr = 0;
        rd(0, r); chk(r == GIE, "R11 enable reads new value", r, GIE);
        do_reti;
        wr(2, 16'h0000);

        // R4 event in decision cycle waits
        wr(0, GIE | 16'h0100);
        @(negedge clk); evt = N'(1) << 8; insn_done = 1;
        @(negedge clk); evt = '0; insn_done = 0;
        #1 chk(irq_req == 0, "R4 same-cycle event waits", irq_req, 0);
        boundary(8, "");
        do_reti;

        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R4 all expected requests seen", expq.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule